// File: doc/BRIEF.md
# Deferred Status Flag Evaluator

This block stands next to an integer ALU and keeps a record of the last operation that affects the status flags. The record holds an operation class, an operand size (8, 16 or 32 bits), both operands and the result. The six arithmetic status flags (carry, parity, half-carry, zero, sign, overflow) are not computed when the operation runs. They are rebuilt from the saved record whenever the flag word is read. Each operation class has its own rule. A class that leaves a flag alone takes that bit from the stored architectural flag register.

A one-cycle load strobe captures a new record. A materialize strobe writes the rebuilt flag word into the architectural register and marks the record as unknown. While the record is unknown, the rebuilt word is simply the stored register. The whole 16-bit word is always visible, and a read port also picks out any single bit of it by index.

Top module: `lazy_flag_eval`

## Requirements
- R1: After reset the architectural flag register holds 0x0002 and the record is unknown, so the flag word reads 0x0002.
- R2: While the record class is unknown (code 0), every bit of the flag word equals the stored architectural register.
- R3: A load strobe captures the record at the clock edge, and the rebuilt flags reflect it from the next cycle on. A materialize strobe copies the current flag word into the architectural register at the edge and makes the record unknown. When load and materialize coincide, the old record is materialized and the new record is then kept.
- R4: Add (1), add-with-carry (2), subtract (3), subtract-with-borrow (4) and compare (5) set CF to the carry or borrow out of the operand size, using the stored CF as the carry-in for codes 2 and 4. They set AF to the carry or borrow across bit 3, and OF to signed overflow.
- R5: Increment (6) and decrement (7) keep CF from the stored register. Increment sets AF when the low nibble of the result is 0 and sets OF when the result is the most negative value. Decrement sets AF when the low nibble is 0xF and sets OF when the result is the largest positive value.
- R6: Negate (8) sets CF when the operand is nonzero, OF when the operand is the most negative value, and AF when the low nibble of the result is nonzero.
- R7: AND (9), OR (10), XOR (11) and TEST (12) clear CF, AF and OF.
- R8: For every class except unknown, multiply and divide, PF is 1 exactly when bits 7..0 of the result hold an even number of ones, whatever the size.
- R9: For the same classes, ZF is set when the result is zero at the recorded size and SF copies the top bit at that size. Size codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits.
- R10: For shift left (13), with count = bits 7..0 of operand 2, CF is the last bit shifted out, which is 0 once the count exceeds the width. OF is 1 when the top bit of the result differs from the top bit of the operand. AF is 1 when the count's low five bits are nonzero.
- R11: For logical right shift (14) and arithmetic right shift (15), CF is the last bit shifted out, and for the arithmetic shift the shift brings in sign copies. The logical shift sets OF to the operand's top bit only when the count's low five bits equal 1, and clears it otherwise. The arithmetic shift always clears OF. AF follows R10.
- R12: Multiply (16) and divide (17) leave every flag at its stored value.
- R13: The flags sit at bits 0 (CF), 2 (PF), 4 (AF), 6 (ZF), 7 (SF) and 11 (OF). All other bits pass through from the stored register. The single-bit read returns bit `rd_sel` of the flag word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Load strobe for a new record |
| rec_op | input | 5 | Operation class code |
| rec_size | input | 2 | Operand size code |
| rec_a | input | 32 | Operand 1 |
| rec_b | input | 32 | Operand 2 (shift count in bits 7..0) |
| rec_res | input | 32 | Result |
| mat_strobe | input | 1 | Materialize flags into the architectural register |
| rd_sel | input | 4 | Bit index for the single-bit read |
| rd_bit | output | 1 | Selected bit of the flag word |
| flags_word | output | 16 | Rebuilt flag word |
| arch_flags | output | 16 | Architectural flag register |

## Verification
The flag word and the single-bit read are combinational from the stored record. They take their new value in the cycle right after the edge that captures a record. The architectural register takes the materialized word at the strobe edge and shows it in that same following cycle. The bench drives inputs on the falling edge and advances its model at the rising edge. It compares all three outputs at the next falling edge, so each comparison falls exactly one register stage after its stimulus. Load-plus-materialize cycles are checked the same way, with the old record's word expected in the register and the new record's word on the output.

// File: rtl/lfe_pkg.sv
package lfe_pkg;
  localparam int DATA_W = 32;
  localparam int FLAG_W = 16;
  localparam int SEL_W  = $clog2(FLAG_W);

  typedef enum logic [4:0] {
    LF_UNK  = 5'd0,  LF_ADD  = 5'd1,  LF_ADC  = 5'd2,  LF_SUB  = 5'd3,
    LF_SBB  = 5'd4,  LF_CMP  = 5'd5,  LF_INC  = 5'd6,  LF_DEC  = 5'd7,
    LF_NEG  = 5'd8,  LF_AND  = 5'd9,  LF_OR   = 5'd10, LF_XOR  = 5'd11,
    LF_TEST = 5'd12, LF_SHL  = 5'd13, LF_SHR  = 5'd14, LF_SAR  = 5'd15,
    LF_MUL  = 5'd16, LF_DIV  = 5'd17
  } lf_op_e;

  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2} lf_size_e;

  localparam int POS_CF = 0;
  localparam int POS_PF = 2;
  localparam int POS_AF = 4;
  localparam int POS_ZF = 6;
  localparam int POS_SF = 7;
  localparam int POS_OF = 11;

  localparam logic [FLAG_W-1:0] FLAG_MASK =
    FLAG_W'((1 << POS_CF) | (1 << POS_PF) | (1 << POS_AF) |
            (1 << POS_ZF) | (1 << POS_SF) | (1 << POS_OF));

  typedef struct packed {
    lf_op_e            op;
    lf_size_e          size;
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
    logic [DATA_W-1:0] r;
  } lf_rec_t;
endpackage

// File: rtl/lfe_record.sv
module lfe_record
  import lfe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  logic    clear,
  input  lf_rec_t rec_in,
  output lf_rec_t rec_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_q.op   <= LF_UNK;
      rec_q.size <= SZ_8;
      rec_q.a    <= '0;
      rec_q.b    <= '0;
      rec_q.r    <= '0;
    end else if (load) begin
      rec_q <= rec_in;
    end else if (clear) begin
      rec_q.op <= LF_UNK;
    end
  end
endmodule

// File: rtl/lfe_compute.sv
module lfe_compute
  import lfe_pkg::*;
(
  input  lf_rec_t           rec,
  input  logic [FLAG_W-1:0] stored,
  output logic [FLAG_W-1:0] word
);
  function automatic logic [DATA_W-1:0] size_mask(lf_size_e s);
    case (s)
      SZ_8:    return DATA_W'(8'hFF);
      SZ_16:   return DATA_W'(16'hFFFF);
      default: return '1;
    endcase
  endfunction

  function automatic int size_bits(lf_size_e s);
    case (s)
      SZ_8:    return 8;
      SZ_16:   return 16;
      default: return DATA_W;
    endcase
  endfunction

  function automatic logic even_ones(logic [7:0] v);
    return ~^v;
  endfunction

  function automatic logic shl_out(logic [DATA_W-1:0] v, logic [7:0] cnt, int bits);
    int idx;
    logic [DATA_W-1:0] t;
    idx = bits - int'(cnt);
    if (cnt == 8'd0 || idx < 0) return 1'b0;
    t = v >> idx;
    return t[0];
  endfunction

  function automatic logic shr_out(logic [DATA_W-1:0] v, logic [7:0] cnt, int bits, logic arith);
    int idx;
    logic [DATA_W-1:0] t;
    if (cnt == 8'd0) return 1'b0;
    idx = int'(cnt) - 1;
    if (idx >= bits) begin
      t = v >> (bits - 1);
      return arith & t[0];
    end
    t = v >> idx;
    return t[0];
  endfunction

  logic [DATA_W-1:0] msk, sgn, am, bm, rm;
  logic [7:0]        cnt;
  int                nbits;
  logic              cin, res_based;
  logic              cf, pf, af, zf, sf, of;

  always_comb begin
    msk   = size_mask(rec.size);
    sgn   = msk ^ (msk >> 1);
    am    = rec.a & msk;
    bm    = rec.b & msk;
    rm    = rec.r & msk;
    cnt   = rec.b[7:0];
    nbits = size_bits(rec.size);
    cin   = stored[POS_CF];
    cf = stored[POS_CF]; pf = stored[POS_PF]; af = stored[POS_AF];
    zf = stored[POS_ZF]; sf = stored[POS_SF]; of = stored[POS_OF];
    res_based = 1'b1;
    case (rec.op)
      LF_ADD, LF_ADC: begin
        cf = (rm < am) | ((rec.op == LF_ADC) & cin & (rm == am));
        af = (am[4] ^ bm[4] ^ rm[4]);
        of = |((am ^ bm ^ sgn) & (rm ^ bm) & sgn);
      end
      LF_SUB, LF_CMP: begin
        cf = (am < bm);
        af = (am[4] ^ bm[4] ^ rm[4]);
        of = |((am ^ bm) & (am ^ rm) & sgn);
      end
      LF_SBB: begin
        cf = (am < rm) | (cin & (bm == msk));
        af = (am[4] ^ bm[4] ^ rm[4]);
        of = |((am ^ bm) & (am ^ rm) & sgn);
      end
      LF_INC: begin
        af = (rm[3:0] == 4'h0);
        of = (rm == sgn);
      end
      LF_DEC: begin
        af = (rm[3:0] == 4'hF);
        of = (rm == (msk >> 1));
      end
      LF_NEG: begin
        cf = (am != '0);
        af = (rm[3:0] != 4'h0);
        of = (am == sgn);
      end
      LF_AND, LF_OR, LF_XOR, LF_TEST: begin
        cf = 1'b0; af = 1'b0; of = 1'b0;
      end
      LF_SHL: begin
        cf = shl_out(am, cnt, nbits);
        of = |((rm ^ am) & sgn);
        af = (cnt[4:0] != 5'd0);
      end
      LF_SHR: begin
        cf = shr_out(am, cnt, nbits, 1'b0);
        of = (cnt[4:0] == 5'd1) & |(am & sgn);
        af = (cnt[4:0] != 5'd0);
      end
      LF_SAR: begin
        cf = shr_out(am, cnt, nbits, 1'b1);
        of = 1'b0;
        af = (cnt[4:0] != 5'd0);
      end
      default: res_based = 1'b0;
    endcase
    if (res_based) begin
      zf = (rm == '0);
      sf = |(rm & sgn);
      pf = even_ones(rm[7:0]);
    end
    word = stored;
    word[POS_CF] = cf;
    word[POS_PF] = pf;
    word[POS_AF] = af;
    word[POS_ZF] = zf;
    word[POS_SF] = sf;
    word[POS_OF] = of;
  end
endmodule

// File: rtl/lazy_flag_eval.sv
module lazy_flag_eval
  import lfe_pkg::*;
#(
  parameter logic [15:0] RST_FLAGS = 16'h0002
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rec_valid,
  input  logic [4:0]  rec_op,
  input  logic [1:0]  rec_size,
  input  logic [31:0] rec_a,
  input  logic [31:0] rec_b,
  input  logic [31:0] rec_res,
  input  logic        mat_strobe,
  input  logic [3:0]  rd_sel,
  output logic        rd_bit,
  output logic [15:0] flags_word,
  output logic [15:0] arch_flags
);
  lf_rec_t           rec_in, rec_q;
  logic [FLAG_W-1:0] arch_q;
  logic [FLAG_W-1:0] word_c;

  always_comb begin
    rec_in.op   = lf_op_e'(rec_op);
    rec_in.size = lf_size_e'(rec_size);
    rec_in.a    = rec_a;
    rec_in.b    = rec_b;
    rec_in.r    = rec_res;
  end

  lfe_record i_record (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (rec_valid),
    .clear  (mat_strobe),
    .rec_in (rec_in),
    .rec_q  (rec_q)
  );

  lfe_compute i_compute (
    .rec    (rec_q),
    .stored (arch_q),
    .word   (word_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          arch_q <= RST_FLAGS;
    else if (mat_strobe) arch_q <= word_c;
  end

  assign flags_word = word_c;
  assign arch_flags = arch_q;
  assign rd_bit     = word_c[rd_sel];

  // Named events for the checks
  logic rec_unknown, rec_logic, rec_incdec, rec_muldiv;
  assign rec_unknown = (rec_q.op == LF_UNK);
  assign rec_logic   = (rec_q.op inside {LF_AND, LF_OR, LF_XOR, LF_TEST});
  assign rec_incdec  = (rec_q.op inside {LF_INC, LF_DEC});
  assign rec_muldiv  = (rec_q.op inside {LF_MUL, LF_DIV});

  AST_UNKNOWN_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    rec_unknown |-> (word_c == arch_q)); // R2
  AST_MAT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    mat_strobe |=> (arch_q == $past(word_c))); // R3
  AST_MAT_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mat_strobe && !rec_valid) |=> rec_unknown); // R3
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> (5'(rec_q.op) == $past(rec_op))); // R3
  AST_INCDEC_CF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rec_incdec |-> (word_c[POS_CF] == arch_q[POS_CF])); // R5
  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rec_logic |-> (!word_c[POS_CF] && !word_c[POS_AF] && !word_c[POS_OF])); // R7
  AST_MULDIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rec_muldiv |-> (word_c == arch_q)); // R12
  AST_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((word_c & ~FLAG_MASK) == (arch_q & ~FLAG_MASK))); // R13
endmodule

// File: tb/test_lazy_flag_eval.sv
`timescale 1ns/1ps
module test_lazy_flag_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0;
  logic [4:0]  rec_op = '0;
  logic [1:0]  rec_size = '0;
  logic [31:0] rec_a = '0, rec_b = '0, rec_res = '0;
  logic        mat_strobe = 1'b0;
  logic [3:0]  rd_sel = '0;
  logic        rd_bit;
  logic [15:0] flags_word, arch_flags;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lazy_flag_eval i_lazy_flag_eval (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_op(rec_op),
    .rec_size(rec_size), .rec_a(rec_a), .rec_b(rec_b), .rec_res(rec_res),
    .mat_strobe(mat_strobe), .rd_sel(rd_sel), .rd_bit(rd_bit),
    .flags_word(flags_word), .arch_flags(arch_flags)
  );

  // model state
  int          m_op = 0, m_sz = 0;
  longint      m_a = 0, m_b = 0, m_r = 0;
  logic [15:0] m_arch = 16'h0002;

  function automatic int width_of(int sz);
    return (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
  endfunction

  function automatic longint to_signed(longint v, int w);
    longint full = longint'(1) << w;
    return (v >= (full >> 1)) ? v - full : v;
  endfunction

  function automatic longint gen_r(int op, int sz, longint a, longint b, bit cin);
    int w = width_of(sz);
    longint full = longint'(1) << w;
    longint m = full - 1;
    longint half = full >> 1;
    longint v = a & m;
    int c = int'(b & 255);
    case (op)
      1: return (a + b) & m;
      2: return (a + b + cin) & m;
      3, 5: return (a - b) & m;
      4: return (a - b - cin) & m;
      6: return (a + 1) & m;
      7: return (a - 1) & m;
      8: return (-a) & m;
      9, 12: return a & b & m;
      10: return (a | b) & m;
      11: return (a ^ b) & m;
      13: begin for (int i = 0; i < c; i++) v = (v << 1) & m; return v; end
      14: begin for (int i = 0; i < c; i++) v = v >> 1; return v; end
      15: begin for (int i = 0; i < c; i++) v = (v >> 1) | (v & half); return v; end
      16: return (a * b) & m;
      default: return a & m;
    endcase
  endfunction

  function automatic logic [15:0] ref_word(int op, int sz, longint a0, longint b0,
                                           longint r0, logic [15:0] arch);
    int w = width_of(sz);
    longint full = longint'(1) << w;
    longint m = full - 1;
    longint half = full >> 1;
    longint a = a0 & m, b = b0 & m, r = r0 & m;
    longint s, v;
    int c, ones;
    bit cin = arch[0];
    bit cf = arch[0], pf = arch[2], af = arch[4], zf = arch[6], sf = arch[7], of = arch[11];
    logic [15:0] res;
    if (op >= 1 && op <= 15) begin
      zf = (r == 0);
      sf = (r >= half);
      ones = 0;
      for (int i = 0; i < 8; i++) ones += int'((r >> i) & 1);
      pf = (ones % 2 == 0);
    end
    c = int'(b0 & 255);
    case (op)
      1, 2: begin
        s = (op == 2) ? longint'(cin) : 0;
        cf = (a + b + s) >= full;
        af = ((a & 15) + (b & 15) + s) > 15;
        v = to_signed(a, w) + to_signed(b, w) + s;
        of = (v >= half) || (v < -half);
      end
      3, 4, 5: begin
        s = (op == 4) ? longint'(cin) : 0;
        cf = a < (b + s);
        af = (a & 15) < ((b & 15) + s);
        v = to_signed(a, w) - to_signed(b, w) - s;
        of = (v >= half) || (v < -half);
      end
      6: begin af = ((a & 15) == 15); of = (a == half - 1); end
      7: begin af = ((a & 15) == 0); of = (a == half); end
      8: begin cf = (a != 0); of = (a == half); af = ((a & 15) != 0); end
      9, 10, 11, 12: begin cf = 0; af = 0; of = 0; end
      13: begin
        v = a; cf = 0;
        for (int i = 0; i < c; i++) begin cf = ((v >> (w - 1)) & 1) != 0; v = (v << 1) & m; end
        of = ((r >= half) != (a >= half));
        af = ((c & 31) != 0);
      end
      14, 15: begin
        v = a; cf = 0;
        for (int i = 0; i < c; i++) begin
          cf = (v & 1) != 0;
          v = (op == 15) ? ((v >> 1) | (v & half)) : (v >> 1);
        end
        of = (op == 14) && ((c & 31) == 1) && (a >= half);
        af = ((c & 31) != 0);
      end
      default: ;
    endcase
    res = arch;
    res[0] = cf; res[2] = pf; res[4] = af; res[6] = zf; res[7] = sf; res[11] = of;
    return res;
  endfunction

  function automatic string req_of(int op);
    case (op)
      0: return "R2";
      1, 2, 3, 4, 5: return "R4";
      6, 7: return "R5";
      8: return "R6";
      9, 10, 11, 12: return "R7";
      13: return "R10";
      14, 15: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag_in);
    logic [15:0] exp_w;
    string tag;
    exp_w = ref_word(m_op, m_sz, m_a, m_b, m_r, m_arch);
    tag = tag_in;
    if (tag == "") begin
      if (flags_word[2] != exp_w[2]) tag = "R8";
      else if (flags_word[7:6] != exp_w[7:6]) tag = "R9";
      else tag = req_of(m_op);
    end
    vectors++;
    if (flags_word !== exp_w) begin
      miscompares++;
      $display("FAIL %s flags_word op=%0d actual=%h expected=%h", tag, m_op, flags_word, exp_w);
    end
    if (arch_flags !== m_arch) begin
      miscompares++;
      $display("FAIL %s arch_flags actual=%h expected=%h",
               (tag_in == "") ? "R3" : tag_in, arch_flags, m_arch);
    end
    if (rd_bit !== exp_w[rd_sel]) begin
      miscompares++;
      $display("FAIL R13 rd_bit sel=%0d actual=%b expected=%b", rd_sel, rd_bit, exp_w[rd_sel]);
    end
  endtask

  task automatic step(bit v, int op, int sz, longint a, longint b, bit mat, int sel);
    logic [15:0] old_w;
    bit cin;
    longint r;
    int w = width_of(sz);
    longint m = (longint'(1) << w) - 1;
    old_w = ref_word(m_op, m_sz, m_a, m_b, m_r, m_arch);
    cin = mat ? old_w[0] : m_arch[0];
    r = gen_r(op, sz, a & m, b & m, cin);
    rec_valid = v; rec_op = 5'(op); rec_size = 2'(sz);
    rec_a = 32'(a); rec_b = 32'(b); rec_res = 32'(r);
    mat_strobe = mat; rd_sel = 4'(sel);
    @(posedge clk);
    if (mat) begin m_arch = old_w; m_op = 0; end
    if (v) begin m_op = op; m_sz = sz; m_a = a; m_b = b; m_r = r; end
    @(negedge clk);
    rec_valid = 1'b0; mat_strobe = 1'b0;
    check("");
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    // R4: byte add wraps to zero with carry and half carry
    step(1, 1, 0, 64'hFF, 64'h01, 0, 0);
    step(0, 0, 0, 0, 0, 1, 6);           // R3 materialize
    // R5: increment keeps stored CF, overflow at 0x7F
    step(1, 6, 0, 64'h7F, 0, 0, 11);
    step(1, 7, 1, 64'h8000, 0, 1, 4);    // R3 load+mat same cycle
    step(1, 8, 2, 64'h0, 0, 0, 0);       // R6 negate zero
    step(1, 8, 0, 64'h80, 0, 1, 11);     // R6 most negative
    step(1, 11, 1, 64'h1234, 64'h1234, 0, 6); // R7
    step(1, 13, 0, 64'h81, 64'd9, 0, 0);      // R10 count above width
    step(1, 13, 1, 64'h8001, 64'd17, 0, 0);
    step(1, 13, 0, 64'h81, 64'd1, 1, 11);
    step(1, 14, 0, 64'h80, 64'd1, 0, 11);     // R11 OF for count 1
    step(1, 14, 0, 64'h81, 64'd2, 0, 0);
    step(1, 15, 0, 64'h80, 64'd10, 1, 0);     // R11 sign fill
    step(1, 2, 2, 64'hFFFFFFFF, 64'h0, 0, 0); // R4 carry-in from stored CF
    step(1, 3, 2, 64'h0, 64'h1, 1, 0);        // R4 32-bit borrow
    step(1, 4, 1, 64'h0, 64'hFFFF, 0, 0);
    step(1, 16, 2, 64'h10000, 64'h10000, 0, 0); // R12
    step(0, 0, 0, 0, 0, 1, 0);
    step(1, 17, 0, 0, 0, 0, 2);
    step(0, 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 600; k++) begin
      int op, sz;
      longint a, b;
      op = int'($urandom_range(17, 1));
      sz = int'($urandom_range(2, 0));
      a  = longint'($urandom);
      b  = longint'($urandom);
      if (op >= 13 && op <= 15) b = longint'($urandom_range(31, 1));
      step($urandom_range(9, 0) < 7, op, sz, a, b, $urandom_range(9, 0) < 3,
           int'($urandom_range(15, 0)));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule